// File: doc/BRIEF.md
# GPU Page Table Walker

This block translates a GPU virtual page number by walking a four-level page table held in memory. It reads one 64-bit entry per level: three directory levels (top, middle, bottom) and then a leaf. It returns either the final leaf entry or a fault. The walker takes one request at a time. It issues one memory read for each level and waits for that read's response before it issues the next.

A directory entry can carry a span field. A span of zero keeps the native page size. A non-zero span is latched for the rest of the walk, and the only legal non-zero value is 9. At the bottom directory level the latched span has two effects. It can make that entry the final translation. When the entry's fragment flag is set, it also redefines the leaf index as a field of the page number whose width is the latched span and whose shift is the bottom entry's own span.

Entry layout:
- bit 0: valid
- bit 1: fragment flag
- bit 54: present
- bits 63:59: span
- bits 47:6: base of the next table

Top module: `gpu_pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, and mem_req_valid_o and res_valid_o are 0.
- R2: The first read goes to req_base_i + 8*vpn[35:27]. Each later read goes to {entry[47:6],6'b0} + 8*index, modulo 2^48. The index is vpn[26:18] for the middle level and vpn[17:9] for the bottom level. For the leaf it is vpn[8:0], unless R6 applies.
- R3: With all spans zero and the present bit clear, a walk makes four reads in order: top, middle, bottom, leaf. It then returns the leaf entry with res_fault_o=0.
- R4: A valid bottom directory entry with present bit 54 set ends the walk after three reads. That entry is returned without a fault.
- R5: A bottom directory entry whose fragment flag (bit 1) is clear ends the walk as the result if a non-zero span (bits 63:59) has been latched during the walk from any directory level, including the bottom entry itself.
- R6: If the bottom entry descends and its fragment flag is set, the leaf index is (vpn >> S_bottom) & (2^S_latched - 1). Here S_bottom is that entry's own span.
- R7: A valid directory entry with a span other than 0 or 9 ends the walk at once. The result has res_fault_o=1 and res_span_err_o=1, carries that entry, and no further read is made.
- R8: An entry whose valid bit 0 is clear, at any level, ends the walk with res_fault_o=1 and res_span_err_o=0, and carries that entry. A non-fault result always has bit 0 set.
- R9: The latched span is cleared at the start of each walk. A span from an earlier walk has no effect on a later one.
- R10: Only one walk runs at a time. req_ready_o is 1 only while idle, and a request presented while busy is ignored.
- R11: Every read request and every result is a one-cycle pulse. Each accepted walk yields exactly one result, after its last read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_vpn_i | input | 36 | Virtual page number (virtual address bits 47:12) |
| req_base_i | input | 48 | Byte address of the top-level table |
| mem_req_valid_o | output | 1 | Memory read request pulse |
| mem_req_addr_o | output | 48 | Byte address of the 8-byte entry to read |
| mem_rsp_valid_i | input | 1 | Read response strobe |
| mem_rsp_data_i | input | 64 | Entry returned by memory |
| res_valid_o | output | 1 | Walk result pulse |
| res_entry_o | output | 64 | Final entry, or the entry that caused the fault |
| res_fault_o | output | 1 | Walk ended without a translation |
| res_span_err_o | output | 1 | Fault caused by an unsupported span |

## Verification
The assertions check the handshake shape on every cycle:
- reads and results are single pulses;
- no read is issued while the walker reports idle;
- an accepted request issues a read on the next cycle;
- a span error always comes with a fault;
- a clean result always has its valid bit set.

Only the bench scenarios can show that the walk is correct. They check the read addresses against a behavioural walk of a sparse memory image, the early end at the bottom level through the present bit or a latched span, and the fragment-indexed leaf. They also check the fault paths, that no span carries over between walks, and that requests arriving mid-walk are ignored.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int unsigned ENTRY_W  = 64;
  localparam int unsigned VLD_BIT  = 0;
  localparam int unsigned FRAG_BIT = 1;
  localparam int unsigned TBL_LSB  = 6;
  localparam int unsigned PRES_BIT = 54;
  localparam int unsigned SPAN_LSB = 59;
  localparam int unsigned SPAN_W   = 5;
  localparam int unsigned ENT_SH   = 3;  // 8-byte entries

  typedef enum logic [1:0] {LV_TOP = 2'd0, LV_MID = 2'd1, LV_BOT = 2'd2, LV_LEAF = 2'd3} lvl_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;
endpackage

// File: rtl/pt_entry_dec.sv
module pt_entry_dec
  import pt_walk_pkg::*;
#(
  parameter int unsigned AW      = 48,
  parameter int unsigned SPAN_OK = 9
) (
  input  logic [AW-1:TBL_LSB] tbl_bits_i,
  input  logic [SPAN_W-1:0]   span_i,
  input  logic [SPAN_W-1:0]   held_i,
  output logic [AW-1:0]       tbl_o,
  output logic [SPAN_W-1:0]   eff_o,
  output logic                span_bad_o
);
  assign tbl_o      = {tbl_bits_i, {TBL_LSB{1'b0}}};
  // a fresh non-zero span overrides the latched one
  assign eff_o      = (span_i != '0) ? span_i : held_i;
  assign span_bad_o = (span_i != '0) && (span_i != SPAN_W'(SPAN_OK));
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walk_pkg::*;
#(
  parameter int unsigned AW    = 48,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned VPN_W = 36
) (
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [AW-1:0]     tbl_i,
  input  lvl_e              lvl_i,
  input  logic              frag_i,
  input  logic [SPAN_W-1:0] len_i,
  input  logic [SPAN_W-1:0] shift_i,
  output logic [AW-1:0]     addr_o
);
  localparam logic [VPN_W-1:0] IDX_MASK = VPN_W'((64'd1 << IDX_W) - 64'd1);

  logic [AW-1:0]    lvl_idx [4];
  logic [VPN_W-1:0] frag_mask;
  logic [AW-1:0]    frag_idx;
  logic [AW-1:0]    idx;

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    assign lvl_idx[g] = AW'((vpn_i >> ((3 - g) * IDX_W)) & IDX_MASK);
  end

  assign frag_mask = (VPN_W'(1) << len_i) - VPN_W'(1);
  assign frag_idx  = AW'((vpn_i >> shift_i) & frag_mask);
  assign idx       = (lvl_i == LV_LEAF && frag_i) ? frag_idx : lvl_idx[lvl_i];
  assign addr_o    = tbl_i + (idx << ENT_SH);
endmodule

// File: rtl/gpu_pt_walker.sv
module gpu_pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned AW      = 48,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned PG_SH   = 12,
  parameter int unsigned SPAN_OK = 9,
  localparam int unsigned VPN_W  = AW - PG_SH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic [AW-1:0]      req_base_i,
  output logic               mem_req_valid_o,
  output logic [AW-1:0]      mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0] mem_rsp_data_i,
  output logic               res_valid_o,
  output logic [ENTRY_W-1:0] res_entry_o,
  output logic               res_fault_o,
  output logic               res_span_err_o
);
  st_e                state_q;
  lvl_e               lvl_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [SPAN_W-1:0]  held_q;
  logic [AW-1:0]      addr_q;
  logic               mreq_q;
  logic               res_vld_q, res_flt_q, res_err_q;
  logic [ENTRY_W-1:0] res_ent_q;

  logic [AW-1:0]      tbl_c, agen_tbl, agen_addr;
  logic [SPAN_W-1:0]  span_c, eff_c;
  logic               span_bad_c, vld_c, frag_c, pres_c;
  logic [VPN_W-1:0]   agen_vpn;
  lvl_e               agen_lvl, lvl_nxt;
  logic               done_c, fault_c, err_c;

  assign vld_c   = mem_rsp_data_i[VLD_BIT];
  assign frag_c  = mem_rsp_data_i[FRAG_BIT];
  assign pres_c  = mem_rsp_data_i[PRES_BIT];
  assign span_c  = mem_rsp_data_i[SPAN_LSB +: SPAN_W];
  assign lvl_nxt = lvl_e'(lvl_q + 2'd1);

  pt_entry_dec #(.AW(AW), .SPAN_OK(SPAN_OK)) u_dec (
    .tbl_bits_i (mem_rsp_data_i[AW-1:TBL_LSB]),
    .span_i     (span_c),
    .held_i     (held_q),
    .tbl_o      (tbl_c),
    .eff_o      (eff_c),
    .span_bad_o (span_bad_c)
  );

  always_comb begin
    if (state_q == ST_IDLE) begin
      agen_vpn = req_vpn_i;
      agen_tbl = req_base_i;
      agen_lvl = LV_TOP;
    end else begin
      agen_vpn = vpn_q;
      agen_tbl = tbl_c;
      agen_lvl = lvl_nxt;
    end
  end

  pt_addr_gen #(.AW(AW), .IDX_W(IDX_W), .VPN_W(VPN_W)) u_agen (
    .vpn_i   (agen_vpn),
    .tbl_i   (agen_tbl),
    .lvl_i   (agen_lvl),
    .frag_i  (frag_c),
    .len_i   (eff_c),
    .shift_i (span_c),
    .addr_o  (agen_addr)
  );

  // walk termination decision for the entry arriving now
  always_comb begin
    done_c  = 1'b0;
    fault_c = 1'b0;
    err_c   = 1'b0;
    if (!vld_c) begin
      done_c  = 1'b1;
      fault_c = 1'b1;
    end else if (lvl_q != LV_LEAF && span_bad_c) begin
      done_c  = 1'b1;
      fault_c = 1'b1;
      err_c   = 1'b1;
    end else if (lvl_q == LV_LEAF) begin
      done_c = 1'b1;
    end else if (lvl_q == LV_BOT && (pres_c || (eff_c != '0 && !frag_c))) begin
      done_c = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lvl_q     <= LV_TOP;
      vpn_q     <= '0;
      held_q    <= '0;
      addr_q    <= '0;
      mreq_q    <= 1'b0;
      res_vld_q <= 1'b0;
      res_flt_q <= 1'b0;
      res_err_q <= 1'b0;
      res_ent_q <= '0;
    end else begin
      mreq_q    <= 1'b0;
      res_vld_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_q   <= req_vpn_i;
          held_q  <= '0;
          lvl_q   <= LV_TOP;
          addr_q  <= agen_addr;
          mreq_q  <= 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (done_c) begin
            res_vld_q <= 1'b1;
            res_ent_q <= mem_rsp_data_i;
            res_flt_q <= fault_c;
            res_err_q <= err_c;
            state_q   <= ST_IDLE;
          end else begin
            held_q <= eff_c;
            lvl_q  <= lvl_nxt;
            addr_q <= agen_addr;
            mreq_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = mreq_q;
  assign mem_req_addr_o  = addr_q;
  assign res_valid_o     = res_vld_q;
  assign res_entry_o     = res_ent_q;
  assign res_fault_o     = res_flt_q;
  assign res_span_err_o  = res_err_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned EW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          mem_req_valid_o,
  input logic          res_valid_o,
  input logic [EW-1:0] res_entry_o,
  input logic          res_fault_o,
  input logic          res_span_err_o
);
  assert_no_read_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && mem_req_valid_o));

  assert_res_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> req_ready_o);

  assert_read_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |=> !mem_req_valid_o);

  assert_res_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_accept_issue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (mem_req_valid_o && !req_ready_o));

  assert_err_faults_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_span_err_o) |-> res_fault_o);

  assert_clean_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_fault_o) |-> res_entry_o[0]);
endmodule

bind gpu_pt_walker pt_walker_chk #(.EW(64)) u_chk (.*);

// File: tb/sim_gpu_pt_walker.sv
`timescale 1ns/1ps
module sim_gpu_pt_walker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [35:0] req_vpn_i = '0;
  logic [47:0] req_base_i = '0;
  logic        mem_req_valid_o;
  logic [47:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        res_valid_o;
  logic [63:0] res_entry_o;
  logic        res_fault_o;
  logic        res_span_err_o;

  always #2 clk = ~clk;  // 250 MHz

  gpu_pt_walker u0 (.clk_i(clk), .*);

  bit [63:0]   mem [bit [47:0]];
  logic [47:0] exp_q [$];
  logic [63:0] exp_entry;
  logic        exp_fault, exp_err;
  bit          busy = 0;
  string       tag = "R1";
  int          lat = 1;
  int          done_cnt = 0;
  int          vec = 0, bad = 0;
  bit          pend = 0;
  int          pcnt = 0;
  logic [47:0] paddr;

  function automatic bit [63:0] mk(input logic [47:0] t, input bit v, f, p, input logic [4:0] s);
    return {s, 4'b0, p, 6'b0, t[47:6], 4'b0, f, v};
  endfunction

  function automatic bit [63:0] rd(input logic [47:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [35:0] vpn_of(input int i2, i1, i0, it);
    return {i2[8:0], i1[8:0], i0[8:0], it[8:0]};
  endfunction

  // behavioural walk: fills expected read queue and result
  function automatic void ref_walk(input logic [35:0] vpn, input logic [47:0] base);
    logic [47:0] a, idx;
    logic [63:0] e;
    int held = 0;
    int sp;
    a = base + (48'((vpn >> 27) & 36'h1FF) << 3);
    for (int lvl = 0; lvl < 4; lvl++) begin
      exp_q.push_back(a);
      e = rd(a);
      exp_entry = e;
      exp_fault = 1'b0;
      exp_err = 1'b0;
      if (!e[0]) begin exp_fault = 1'b1; return; end
      if (lvl == 3) return;
      sp = int'(e[63:59]);
      if (sp != 0) begin
        if (sp != 9) begin exp_fault = 1'b1; exp_err = 1'b1; return; end
        held = sp;
      end
      if (lvl == 2 && (e[54] || (held != 0 && !e[1]))) return;
      if (lvl < 2) idx = 48'((vpn >> (9 * (2 - lvl))) & 36'h1FF);
      else if (e[1]) idx = 48'((vpn >> sp) & ((36'd1 << held) - 36'd1));
      else idx = 48'(vpn & 36'h1FF);
      a = (e[47:0] & ~48'h3F) + (idx << 3);
    end
  endfunction

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] expv);
    vec++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual %h expected %h", t, act, expv);
    end
  endtask

  // per-clock reference comparison and memory responder
  always @(negedge clk) begin
    if (res_valid_o) begin
      if (!busy) chk("R11 result without walk", 64'd1, 64'd0);
      else begin
        chk({tag, " entry"}, res_entry_o, exp_entry);
        chk({tag, " fault"}, 64'(res_fault_o), 64'(exp_fault));
        chk({tag, " span_err"}, 64'(res_span_err_o), 64'(exp_err));
        chk("R11 reads left", 64'(exp_q.size()), 64'd0);
      end
      busy = 0;
      done_cnt++;
    end
    chk("R10 ready", 64'(req_ready_o), 64'(!busy));
    mem_rsp_valid_i = 1'b0;
    if (pend) begin
      pcnt--;
      if (pcnt == 0) begin
        pend = 0;
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = rd(paddr);
      end
    end
    if (mem_req_valid_o) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", 64'd1, 64'd0);
      else chk({"R2 read addr ", tag}, 64'(mem_req_addr_o), 64'(exp_q.pop_front()));
      pend = 1;
      pcnt = lat;
      paddr = mem_req_addr_o;
    end
    if (rst_ni && req_valid_i && req_ready_o && !busy) begin
      busy = 1;
      exp_q.delete();
      ref_walk(req_vpn_i, req_base_i);
    end
  end

  task automatic chain(input logic [47:0] base, input int i2, i1, i0, it,
                       input logic [4:0] s2, s1, s0, input bit f0, p0, input logic [47:0] rg);
    logic [47:0] t1, t0, tp;
    t1 = rg + 48'h1000; t0 = rg + 48'h2000; tp = rg + 48'h3000;
    mem[base + 48'(i2 * 8)] = mk(t1, 1, 0, 0, s2);
    mem[t1 + 48'(i1 * 8)]   = mk(t0, 1, 0, 0, s1);
    mem[t0 + 48'(i0 * 8)]   = mk(tp, 1, f0, p0, s0);
    mem[tp + 48'(i0 * 8)]   = mk(rg + 48'h6000, 1, 0, 0, 0);
    mem[tp + 48'(it * 8)]   = mk(rg + 48'h5000, 1, 0, 0, 0);
  endtask

  task automatic launch(input logic [35:0] vpn, input logic [47:0] base, input int l, input string t);
    lat = l;
    tag = t;
    @(posedge clk); #1;
    req_valid_i = 1'b1; req_vpn_i = vpn; req_base_i = base;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done(input int d);
    while (done_cnt == d) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic walk(input logic [35:0] vpn, input logic [47:0] base, input int l, input string t);
    int d = done_cnt;
    launch(vpn, base, l, t);
    wait_done(d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk); #0.5;
    chk("R1 ready", 64'(req_ready_o), 64'd1);
    chk("R1 mem_req", 64'(mem_req_valid_o), 64'd0);
    chk("R1 res_valid", 64'(res_valid_o), 64'd0);

    chain(48'h10000, 3, 5, 7, 9, 0, 0, 0, 0, 0, 48'h100000);
    walk(vpn_of(3, 5, 7, 9), 48'h10000, 1, "R3");
    chain(48'h20000, 511, 0, 511, 1, 0, 0, 0, 0, 0, 48'h200000);
    walk(vpn_of(511, 0, 511, 1), 48'h20000, 4, "R3");
    chain(48'h30000, 1, 2, 3, 4, 0, 0, 0, 0, 1, 48'h300000);
    walk(vpn_of(1, 2, 3, 4), 48'h30000, 2, "R4");
    chain(48'h40000, 2, 3, 4, 5, 0, 9, 0, 0, 0, 48'h400000);
    walk(vpn_of(2, 3, 4, 5), 48'h40000, 1, "R5");
    chain(48'h48000, 2, 3, 4, 5, 0, 0, 9, 0, 0, 48'h480000);
    walk(vpn_of(2, 3, 4, 5), 48'h48000, 2, "R5");
    chain(48'h50000, 6, 7, 8, 10, 9, 0, 9, 1, 0, 48'h500000);
    walk(vpn_of(6, 7, 8, 10), 48'h50000, 3, "R6");
    chain(48'h60000, 6, 7, 8, 10, 0, 9, 0, 1, 0, 48'h600000);
    walk(vpn_of(6, 7, 8, 10), 48'h60000, 1, "R6");
    chain(48'h70000, 1, 1, 1, 1, 0, 5, 0, 0, 0, 48'h700000);
    walk(vpn_of(1, 1, 1, 1), 48'h70000, 2, "R7");
    chain(48'hC0000, 4, 4, 4, 4, 12, 0, 0, 0, 0, 48'hC00000);
    walk(vpn_of(4, 4, 4, 4), 48'hC0000, 1, "R7");
    walk(vpn_of(9, 9, 9, 9), 48'h80000, 1, "R8");
    chain(48'h90000, 1, 2, 3, 4, 0, 0, 0, 0, 0, 48'h900000);
    mem[48'h903000 + 48'd32] = mk(48'h123440, 0, 1, 0, 0);
    walk(vpn_of(1, 2, 3, 4), 48'h90000, 3, "R8");
    walk(vpn_of(2, 3, 4, 5), 48'h40000, 1, "R5");
    chain(48'hA0000, 2, 3, 4, 5, 0, 0, 0, 0, 0, 48'hA00000);
    walk(vpn_of(2, 3, 4, 5), 48'hA0000, 1, "R9");

    chain(48'hB0000, 8, 6, 4, 2, 0, 0, 0, 0, 0, 48'hB00000);
    d = done_cnt;
    launch(vpn_of(8, 6, 4, 2), 48'hB0000, 4, "R10");
    repeat (2) @(posedge clk);
    #1 req_valid_i = 1'b1; req_vpn_i = vpn_of(3, 5, 7, 9); req_base_i = 48'h10000;
    repeat (3) @(posedge clk);
    #1 req_valid_i = 1'b0;
    wait_done(d);
    walk(vpn_of(3, 5, 7, 9), 48'h10000, 1, "R11");

    repeat (4) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule